// File: doc/BRIEF.md
# MDIO Status Poller with Link Monitor

This block runs a management bus without any software command. It sweeps the PHY addresses 0 through 31 in turn and issues one read of the basic status register at each address. From every read it records two facts: whether a device answered at that address, and whether that device reports an active link. Both facts are kept as 32-bit maps indexed by address, so software reads them directly instead of running bus cycles.

Two monitor slots each take an address chosen by software. When a poll of that address returns a link state that differs from the stored one, the slot latches an event. The event raises an interrupt line if that slot's enable is set. Software clears the event with a one-cycle clear pulse. The management clock is made by dividing the core clock by a programmable half-period. Another agent can borrow the bus through a yield request: the engine stops at the next frame boundary, reports that it is idle, and on release carries on with the following address.

Top module: `mdio_poll_monitor`

## Requirements
- R1: Each MDC half period lasts `divSel` core clock cycles, and a `divSel` of 0 gives one cycle. MDC is low during reset.
- R2: The engine changes `mdioOut`/`mdioOe` only on a falling MDC edge and samples `mdioIn` only on a rising MDC edge.
- R3: Each frame is 64 MDC bits. Bits 0-31 drive 1 (preamble). Bits 32-45 drive start `01`, opcode `10`, the 5-bit address MSB first and register address `00001`. Bits 46-63 have `mdioOe` low: two turnaround bits, then 16 data bits MSB first.
- R4: When `mdioIn` is low in the second turnaround bit (frame bit 47), `presentMap[addr]` is set to 1. Otherwise both `presentMap[addr]` and `linkMap[addr]` are set to 0.
- R5: For a present PHY, `linkMap[addr]` takes bit 2 of the 16-bit status word, which is the 14th data bit received.
- R6: Frames run back to back, and the address steps 0, 1, …, 31 and then wraps to 0.
- R7: Slot 0 watches `monAddrA` and slot 1 watches `monAddrB`. `linkEvent[m]` is latched when a poll of the watched address yields a link value that differs from the `linkMap` bit it replaces. Since `linkMap` resets to 0, a PHY that is up at its first poll also latches an event.
- R8: `linkIrq[m]` is high exactly while `linkEvent[m]` and `monIntEn[m]` are both high.
- R9: A high `evtClear[m]` clears `linkEvent[m]` at the next clock edge. A new event arriving in the same cycle wins over the clear.
- R10: When `yieldReq` is high at the end of a frame, the engine holds with `pollIdle` high and `mdioOe` low, and the maps stay unchanged. After `yieldReq` falls, polling restarts at the next address on a falling MDC edge.
- R11: During reset both maps, both events and `pollIdle` are 0, and the bus drives preamble (`mdioOe`=1, `mdioOut`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divSel | input | DIV_W | MDC half period in core cycles (0 acts as 1) |
| yieldReq | input | 1 | Request to hold polling at the next frame boundary |
| pollIdle | output | 1 | Engine is holding and the bus is released |
| monAddrA | input | 5 | Address watched by monitor slot 0 |
| monAddrB | input | 5 | Address watched by monitor slot 1 |
| monIntEn | input | 2 | Per-slot interrupt enable |
| evtClear | input | 2 | Per-slot event clear, one cycle high |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data driven toward the bus |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Data read from the bus |
| presentMap | output | 32 | Per-address responder map |
| linkMap | output | 32 | Per-address link-up map |
| linkEvent | output | 2 | Latched link-change event per slot |
| linkIrq | output | 2 | Interrupt per slot |

## Verification
Map bits and events are written on the core clock edge where MDC falls at the end of frame bit 63. The bench decodes frame headers from the bus and waits on a header count rather than on cycle numbers, and it allows one extra sweep whenever the PHY model changes mid-frame. A clear takes effect on the next core edge, and the interrupt follows the event in the same cycle, so the bench samples both one negative core edge after the pulse. All sampling takes place on negative core edges, half a cycle away from the edges where the outputs change.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
  localparam int ADDR_W     = 5;
  localparam int NUM_ADDR   = 1 << ADDR_W;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int HDR_FIRST  = 32;
  localparam int HDR_LAST   = 45;
  localparam int TA_SAMPLE  = 47;
  localparam int DATA_FIRST = 48;
  localparam int DATA_W     = 16;
  localparam int SLOTS      = 2;

  typedef struct packed {
    logic active;     // a frame is running on the bus
    logic sampleTa;   // rising MDC in the second turnaround bit
    logic shiftData;  // rising MDC in a data bit
    logic commit;     // falling MDC closing the last bit
  } pollStrb_t;
endpackage

// File: rtl/mdio_poll_ctrl.sv
module mdio_poll_ctrl
  import mdio_poll_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              yieldReq,
  output logic              mdc,
  output logic [CNT_W-1:0]  bitIdx,
  output logic [ADDR_W-1:0] pollAddr,
  output logic              pollIdle,
  output pollStrb_t         strb
);
  typedef enum logic { ST_RUN, ST_HOLD } state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLen;
  logic             tick, riseEv, fallEv, lastBit;

  assign halfLen = (divSel == '0) ? DIV_W'(1) : divSel;
  assign tick    = (divCnt >= halfLen - DIV_W'(1));
  assign riseEv  = tick & ~mdc;
  assign fallEv  = tick & mdc;
  assign lastBit = (bitIdx == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      mdc    <= ~mdc;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      bitIdx   <= '0;
      pollAddr <= '0;
    end else if (fallEv) begin
      case (state)
        ST_RUN: begin
          if (lastBit) begin
            bitIdx   <= '0;
            pollAddr <= pollAddr + ADDR_W'(1);
            if (yieldReq) state <= ST_HOLD;
          end else begin
            bitIdx <= bitIdx + CNT_W'(1);
          end
        end
        default: if (!yieldReq) state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strb.active    = (state == ST_RUN);
    strb.sampleTa  = riseEv && strb.active && (bitIdx == CNT_W'(TA_SAMPLE));
    strb.shiftData = riseEv && strb.active && (bitIdx >= CNT_W'(DATA_FIRST));
    strb.commit    = fallEv && strb.active && lastBit;
  end

  assign pollIdle = (state == ST_HOLD);

  // R2: bit position advances only together with a falling MDC
  a_r2_bit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bitIdx) |-> $fell(mdc));
  // R6: address moves by exactly one, wrapping
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pollAddr) |-> (pollAddr == ADDR_W'($past(pollAddr) + ADDR_W'(1))));
  // R10: holding starts only at a frame boundary on a falling MDC
  a_r10_hold_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pollIdle) |-> (bitIdx == '0) && $fell(mdc));
endmodule

// File: rtl/mdio_poll_dp.sv
module mdio_poll_dp
  import mdio_poll_pkg::*;
#(
  parameter int LINK_BIT   = 2,
  parameter int STATUS_REG = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  pollStrb_t                    strb,
  input  logic [CNT_W-1:0]             bitIdx,
  input  logic [ADDR_W-1:0]            pollAddr,
  input  logic [SLOTS-1:0][ADDR_W-1:0] monAddr,
  input  logic [SLOTS-1:0]             monIntEn,
  input  logic [SLOTS-1:0]             evtClear,
  input  logic                         mdioIn,
  output logic                         mdioOut,
  output logic                         mdioOe,
  output logic [NUM_ADDR-1:0]          presentMap,
  output logic [NUM_ADDR-1:0]          linkMap,
  output logic [SLOTS-1:0]             linkEvent,
  output logic [SLOTS-1:0]             linkIrq
);
  localparam int HDR_W = HDR_LAST - HDR_FIRST + 1;

  logic [HDR_W-1:0]  hdr;
  logic [CNT_W-1:0]  hdrSel;
  logic              taLow;
  logic [DATA_W-1:0] shiftReg;
  logic              newLink;
  logic [SLOTS-1:0]  setEv;

  assign hdr    = {2'b01, 2'b10, pollAddr, ADDR_W'(STATUS_REG)};
  assign hdrSel = CNT_W'(HDR_LAST) - bitIdx;

  always_comb begin
    mdioOut = 1'b1;
    mdioOe  = 1'b0;
    if (strb.active) begin
      if (bitIdx < CNT_W'(HDR_FIRST)) begin
        mdioOe = 1'b1;
      end else if (bitIdx <= CNT_W'(HDR_LAST)) begin
        mdioOe  = 1'b1;
        mdioOut = hdr[hdrSel[3:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taLow    <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (strb.sampleTa)  taLow    <= ~mdioIn;
      if (strb.shiftData) shiftReg <= {shiftReg[DATA_W-2:0], mdioIn};
    end
  end

  assign newLink = taLow & shiftReg[LINK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presentMap <= '0;
      linkMap    <= '0;
    end else if (strb.commit) begin
      presentMap[pollAddr] <= taLow;
      linkMap[pollAddr]    <= newLink;
    end
  end

  for (genvar m = 0; m < SLOTS; m++) begin : g_slot
    assign setEv[m] = strb.commit && (pollAddr == monAddr[m]) &&
                      (linkMap[pollAddr] != newLink);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           linkEvent[m] <= 1'b0;
      else if (setEv[m])    linkEvent[m] <= 1'b1;
      else if (evtClear[m]) linkEvent[m] <= 1'b0;
    end

    assign linkIrq[m] = linkEvent[m] & monIntEn[m];

    // R7: an event appears only at the close of a poll frame
    a_r7_event_on_poll: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(linkEvent[m]) |-> $past(strb.commit));
    // R9: a clear without a concurrent event empties the slot
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (evtClear[m] && !setEv[m]) |=> !linkEvent[m]);
  end

  // R4: a frame with no turnaround response clears the presence bit
  a_r4_absent_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && !taLow) |=> !presentMap[$past(pollAddr)]);
  // R5: link is never reported for an address with no responder
  a_r5_link_needs_present: assert property (@(posedge clk) disable iff (!rst_n)
    (linkMap & ~presentMap) == '0);
  // R10: bus is released whenever no frame runs
  a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.active |-> !mdioOe);
endmodule

// File: rtl/mdio_poll_monitor.sv
module mdio_poll_monitor
  import mdio_poll_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int LINK_BIT   = 2,
  parameter int STATUS_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              yieldReq,
  output logic              pollIdle,
  input  logic [4:0]        monAddrA,
  input  logic [4:0]        monAddrB,
  input  logic [1:0]        monIntEn,
  input  logic [1:0]        evtClear,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn,
  output logic [31:0]       presentMap,
  output logic [31:0]       linkMap,
  output logic [1:0]        linkEvent,
  output logic [1:0]        linkIrq
);
  pollStrb_t                    strb;
  logic [CNT_W-1:0]             bitIdx;
  logic [ADDR_W-1:0]            pollAddr;
  logic [SLOTS-1:0][ADDR_W-1:0] monAddr;

  assign monAddr = {monAddrB, monAddrA};

  mdio_poll_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .divSel(divSel), .yieldReq(yieldReq),
    .mdc(mdc), .bitIdx(bitIdx), .pollAddr(pollAddr), .pollIdle(pollIdle),
    .strb(strb)
  );

  mdio_poll_dp #(.LINK_BIT(LINK_BIT), .STATUS_REG(STATUS_REG)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .bitIdx(bitIdx),
    .pollAddr(pollAddr), .monAddr(monAddr), .monIntEn(monIntEn),
    .evtClear(evtClear), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .presentMap(presentMap), .linkMap(linkMap),
    .linkEvent(linkEvent), .linkIrq(linkIrq)
  );
endmodule

// File: tb/mdio_poll_monitor_test.sv
module mdio_poll_monitor_test;
  localparam int WDOG = 150000;
  // {present, address[4:0], status[15:0]}
  localparam logic [21:0] PHY_TABLE [6] = '{
    {1'b1, 5'd0,  16'h7849},
    {1'b1, 5'd3,  16'h786D},
    {1'b1, 5'd17, 16'h0004},
    {1'b0, 5'd9,  16'hFFFF},
    {1'b1, 5'd31, 16'hFFFB},
    {1'b1, 5'd12, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] divSel = 8'd1;
  logic yieldReq = 1'b0;
  logic [4:0] monAddrA = 5'd3, monAddrB = 5'd17;
  logic [1:0] monIntEn = 2'b01, evtClear = 2'b00;
  logic mdioIn = 1'b1;
  logic pollIdle, mdc, mdioOut, mdioOe;
  logic [31:0] presentMap, linkMap;
  logic [1:0] linkEvent, linkIrq;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  mdio_poll_monitor uut (
    .clk(clk), .rst_n(rst_n), .divSel(divSel), .yieldReq(yieldReq),
    .pollIdle(pollIdle), .monAddrA(monAddrA), .monAddrB(monAddrB),
    .monIntEn(monIntEn), .evtClear(evtClear), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn), .presentMap(presentMap),
    .linkMap(linkMap), .linkEvent(linkEvent), .linkIrq(linkIrq)
  );

  always #2 clk = ~clk;

  // PHY model
  bit          phyPresent [32];
  logic [15:0] phyStatus  [32];
  logic [14:0] hdrWin = '0;
  int          phase = 0, frameCount = 0, addrErrs = 0, conflicts = 0;
  logic [4:0]  curAddr = '0, lastAddr = '0;

  always @(posedge mdc) begin
    if (phase > 0 && mdioOe) conflicts++;
    if (mdioOe) begin
      hdrWin = {hdrWin[13:0], mdioOut};
      if (hdrWin[14:10] == 5'b10110 && hdrWin[4:0] == 5'b00001) begin
        curAddr = hdrWin[9:5];
        if (frameCount > 0 && curAddr != 5'(lastAddr + 5'd1)) addrErrs++;
        lastAddr = curAddr;
        frameCount++;
        phase = 1;
        hdrWin = '0;
      end
    end
  end

  always @(negedge mdc) begin
    if (phase == 1) begin
      mdioIn = 1'b1; phase = 2;
    end else if (phase == 2) begin
      mdioIn = !phyPresent[curAddr]; phase = 3;
    end else if (phase >= 3 && phase <= 18) begin
      mdioIn = phyPresent[curAddr] ? phyStatus[curAddr][18 - phase] : 1'b1;
      phase++;
    end else if (phase == 19) begin
      mdioIn = 1'b1; phase = 0;
    end
  end

  // R2 observer: no output change while MDC stays high
  int r2Viol = 0;
  logic prevMdc = 1'b0, prevOut = 1'b1, prevOe = 1'b1;
  always @(negedge clk) begin
    if (rst_n && mdc && prevMdc && (mdioOut !== prevOut || mdioOe !== prevOe))
      r2Viol++;
    prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    int target = frameCount + n;
    while (frameCount < target) @(negedge clk);
  endtask

  task automatic measureHalf(input int expHalf, input string req);
    logic m0;
    int n = 0;
    repeat (3) begin
      @(negedge clk); m0 = mdc;
      while (mdc == m0) @(negedge clk);
    end
    m0 = mdc;
    while (mdc == m0) begin @(negedge clk); n++; end
    chk(req, 64'(n), 64'(expHalf));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] expPresent, expLink, heldP, heldL;
    int heldCount;
    logic [4:0] heldAddr;
    for (int i = 0; i < 32; i++) begin phyPresent[i] = 1'b0; phyStatus[i] = '0; end

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 maps", {presentMap, linkMap}, 64'd0);
    chk("R11 events/idle", {linkEvent, linkIrq, pollIdle}, 64'd0);
    chk("R11 bus preamble", {mdioOe, mdioOut}, 64'd3);
    chk("R1 mdc low in reset", 64'(mdc), 64'd0);

    // table walk: configure PHY model
    expPresent = '0; expLink = '0;
    for (int i = 0; i < 6; i++) begin
      phyPresent[PHY_TABLE[i][20:16]] = PHY_TABLE[i][21];
      phyStatus[PHY_TABLE[i][20:16]]  = PHY_TABLE[i][15:0];
      expPresent[PHY_TABLE[i][20:16]] = PHY_TABLE[i][21];
      expLink[PHY_TABLE[i][20:16]]    = PHY_TABLE[i][21] & PHY_TABLE[i][2];
    end
    @(negedge clk); rst_n = 1'b1;
    waitFrames(34);
    for (int i = 0; i < 6; i++) begin
      chk("R4 presence per address", 64'(presentMap[PHY_TABLE[i][20:16]]), 64'(PHY_TABLE[i][21]));
      chk("R5 link per address", 64'(linkMap[PHY_TABLE[i][20:16]]),
          64'(PHY_TABLE[i][21] & PHY_TABLE[i][2]));
    end
    chk("R4 full presence map", 64'(presentMap), 64'(expPresent));
    chk("R5 full link map", 64'(linkMap), 64'(expLink));
    chk("R6 address order", 64'(addrErrs), 64'd0);
    chk("R3 no drive in turnaround/data", 64'(conflicts), 64'd0);
    chk("R3 headers decoded", 64'(frameCount >= 34), 64'd1);

    // R7/R8: first polls of linked monitored PHYs latch events
    chk("R7 events after first poll", 64'(linkEvent), 64'd3);
    chk("R8 irq gated by enable", 64'(linkIrq), 64'd1);

    // R9: clear both
    evtClear = 2'b11; @(negedge clk); evtClear = 2'b00;
    chk("R9 clear", 64'(linkEvent), 64'd0);
    chk("R8 irq after clear", 64'(linkIrq), 64'd0);

    // R7: link drop on slot 0 PHY
    phyStatus[3] = 16'h7869;
    waitFrames(34);
    chk("R7 slot0 event on link drop", 64'(linkEvent), 64'd1);
    chk("R8 slot0 irq", 64'(linkIrq), 64'd1);
    chk("R5 link bit cleared", 64'(linkMap[3]), 64'd0);

    // R4: PHY at 17 disappears; slot 1 event but irq disabled
    phyPresent[17] = 1'b0;
    waitFrames(34);
    chk("R4 absent clears presence", 64'(presentMap[17]), 64'd0);
    chk("R4 absent clears link", 64'(linkMap[17]), 64'd0);
    chk("R7 slot1 event", 64'(linkEvent[1]), 64'd1);
    chk("R8 slot1 irq disabled", 64'(linkIrq[1]), 64'd0);
    evtClear = 2'b11; @(negedge clk); evtClear = 2'b00;

    // R10: yield
    yieldReq = 1'b1;
    while (!pollIdle) @(negedge clk);
    heldCount = frameCount; heldAddr = lastAddr;
    heldP = presentMap; heldL = linkMap;
    phyPresent[12] = 1'b0;
    chk("R10 bus released", 64'(mdioOe), 64'd0);
    repeat (400) @(negedge clk);
    chk("R10 still idle", 64'(pollIdle), 64'd1);
    chk("R10 no frames", 64'(frameCount), 64'(heldCount));
    chk("R10 maps held", {heldP, heldL}, {presentMap, linkMap});
    chk("R10 no events while held", 64'(linkEvent), 64'd0);
    yieldReq = 1'b0;
    waitFrames(2);
    chk("R10 resume at next address", 64'(lastAddr), 64'(5'(heldAddr + 5'd2)));
    chk("R10 idle dropped", 64'(pollIdle), 64'd0);
    phyPresent[12] = 1'b1;

    chk("R2 outputs stable while mdc high", 64'(r2Viol), 64'd0);
    chk("R6 address order overall", 64'(addrErrs), 64'd0);

    // R1: divider
    divSel = 8'd3;
    measureHalf(3, "R1 half period div 3");
    divSel = 8'd0;
    measureHalf(1, "R1 half period div 0");
    divSel = 8'd1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule